// File: doc/BRIEF.md
# IEEE 1284 Mode Negotiation Controller

This block is the host side of a parallel-port link that must leave compatibility mode for an IEEE 1284 mode and later return to it. A one-cycle start request carries an 8-bit mode code. The controller puts that code on the data lines, runs the event handshake on the four host control lines and watches the five peripheral status lines. When the sequence ends it reports a result code. A separate one-cycle request runs the termination handshake, which brings the link back to compatibility. Data transfer phases are not part of this block.

All timing limits count pulses of an external tick strobe. Each wait state starts its own count from zero. The peripheral status lines pass through a parameterised chain of flip-flops before the state machine acts on them. After a successful negotiation the block holds the accepted code and an active flag, so the surrounding logic knows which mode the link is in.

Top module: `p1284_negotiator`

## Requirements
- R1: After reset, and whenever the block is idle, `out_nstrobe` is high. Reset values are: `out_nstrobe`, `out_nautofd` and `out_ninit` high, `out_nselectin` low, `data_out` 0, `busy` 0, `result` 0 and `mode_active` 0.
- R2: A start request while idle with `out_nselectin` high is refused in the next cycle. `done` rises with `result` = 2 (I/O error), and no data or control line changes.
- R3: An accepted start puts the code on `data_out` and waits SETUP_TICKS ticks. It then drives `out_nselectin` high and `out_nautofd` low. Once PError, Select and nFault are all high with nAck low, `out_nstrobe` goes low for SETUP_TICKS ticks. After that, `out_nstrobe` and `out_nautofd` return high.
- R4: If the response pattern of R3 does not appear before the RESP_TICKS-th tick of that wait, the negotiation ends with `result` = 1 (timeout).
- R5: If nAck does not go high within SETUP_TICKS+RESP_TICKS ticks after the strobe, the negotiation ends with `result` = 2.
- R6: When nAck goes high, code 0x00 is always accepted. Any other code is accepted only if Select is high at that moment; otherwise `result` = 3 (mode not supported). On acceptance `result` = 0, `mode_active` = 1 and `cur_mode` holds the code.
- R7: Termination drives `out_nselectin` low with the other three control lines high. It waits for Busy and nFault high with nAck low, then pulls `out_nautofd` low. It waits for nAck high, then raises `out_nautofd` and ends with `result` = 0.
- R8: If the first termination wait exceeds SETUP_TICKS+RESP_TICKS ticks, termination ends with `result` = 2. If the second wait exceeds RESP_TICKS ticks, it also ends with `result` = 2, and `out_nautofd` is driven high again.
- R9: `mode_active` and `cur_mode` are cleared in the first cycle of termination, whether or not termination later completes.
- R10: Start and terminate requests that arrive while `busy` is high are ignored. If both requests arrive together while idle, the start request is served.
- R11: `done` is asserted only while `busy` is low. `result` keeps its value until the next time `done` is asserted.
- R12: A change on a status line takes effect SYNC_STAGES cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timebase strobe, one cycle per tick |
| neg_start | input | 1 | Request a negotiation |
| neg_code | input | DATA_W | Mode code to negotiate |
| term_start | input | 1 | Request termination to compatibility |
| pin_nack | input | 1 | Peripheral nAck |
| pin_busy | input | 1 | Peripheral Busy |
| pin_perror | input | 1 | Peripheral PError |
| pin_select | input | 1 | Peripheral Select |
| pin_nfault | input | 1 | Peripheral nFault |
| data_out | output | DATA_W | Host data lines |
| out_nstrobe | output | 1 | Host nStrobe |
| out_nautofd | output | 1 | Host nAutoFd |
| out_ninit | output | 1 | Host nInit |
| out_nselectin | output | 1 | Host nSelectIn |
| busy | output | 1 | A handshake is in progress |
| done | output | 1 | One-cycle end-of-operation strobe |
| result | output | 2 | 0 ok, 1 timeout, 2 I/O error, 3 not supported |
| mode_active | output | 1 | A negotiated mode is in force |
| cur_mode | output | DATA_W | Code of the mode in force, 0 in compatibility |

## Verification
The bound checker tests these rules on every cycle:
- a refused start produces its immediate I/O-error result;
- the strobe is only ever low inside the negotiation pattern;
- the data lines hold steady while a handshake runs;
- the active flag is clear during termination;
- nAutoFd is high whenever the termination handshake state is left.

The rules that depend on a peripheral's replies need the bench's scripted peripheral to show them:
- the tick-counted timeout windows;
- the acceptance rule for different codes;
- each failure branch and the result it reports;
- the synchroniser latency.

// File: rtl/p1284_pkg.sv
package p1284_pkg;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_N_SETUP,
      PH_N_REQ,
      PH_N_STROBE,
      PH_N_ACK,
      PH_T_REQ,
      PH_T_HSHK
   } phase_t;

   typedef enum logic [1:0] {
      RES_OK      = 2'd0,
      RES_TIMEOUT = 2'd1,
      RES_IOERR   = 2'd2,
      RES_NOSUPP  = 2'd3
   } result_t;

   typedef struct packed {
      logic nack;
      logic busy;
      logic perror;
      logic select;
      logic nfault;
   } periph_t;

   typedef struct packed {
      logic nselectin;
      logic ninit;
      logic nautofd;
      logic nstrobe;
   } hostpins_t;

   localparam hostpins_t PINS_IDLE = '{nselectin: 1'b0, ninit: 1'b1, nautofd: 1'b1, nstrobe: 1'b1};
   localparam hostpins_t PINS_NREQ = '{nselectin: 1'b1, ninit: 1'b1, nautofd: 1'b0, nstrobe: 1'b1};

endpackage

// File: rtl/p1284_status_sync.sv
module p1284_status_sync #(
   parameter int W      = 5,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [W-1:0] stage_q [STAGES];
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
            end else begin
               stage_q[0] <= d;
               for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
            end
         end
         assign q = stage_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/p1284_tick_timer.sv
module p1284_tick_timer #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             tick,
   input  logic [CNT_W-1:0] limit,
   output logic             expire
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)      cnt_q <= '0;
      else if (clr)    cnt_q <= '0;
      else if (tick)   cnt_q <= cnt_q + 1'b1;
   end

   assign expire = tick && (cnt_q == limit - 1'b1);
endmodule

// File: rtl/p1284_event_match.sv
module p1284_event_match
   import p1284_pkg::*;
(
   input  phase_t  ph,
   input  periph_t st,
   output logic    hit
);
   always_comb begin
      unique case (ph)
         PH_N_REQ:  hit = st.perror && st.select && st.nfault && !st.nack;
         PH_N_ACK:  hit = st.nack;
         PH_T_REQ:  hit = st.busy && st.nfault && !st.nack;
         PH_T_HSHK: hit = st.nack;
         default:   hit = 1'b0;
      endcase
   end
endmodule

// File: rtl/p1284_negotiator.sv
module p1284_negotiator
   import p1284_pkg::*;
#(
   parameter int          DATA_W      = 8,
   parameter int          SETUP_TICKS = 1,
   parameter int          RESP_TICKS  = 6,
   parameter int          SYNC_STAGES = 2,
   parameter logic [7:0]  NIBBLE_CODE = 8'h00
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              neg_start,
   input  logic [DATA_W-1:0] neg_code,
   input  logic              term_start,
   input  logic              pin_nack,
   input  logic              pin_busy,
   input  logic              pin_perror,
   input  logic              pin_select,
   input  logic              pin_nfault,
   output logic [DATA_W-1:0] data_out,
   output logic              out_nstrobe,
   output logic              out_nautofd,
   output logic              out_ninit,
   output logic              out_nselectin,
   output logic              busy,
   output logic              done,
   output logic [1:0]        result,
   output logic              mode_active,
   output logic [DATA_W-1:0] cur_mode
);
   localparam int LONG_TICKS = SETUP_TICKS + RESP_TICKS;
   localparam int CNT_W      = $clog2(LONG_TICKS + 1);
   localparam int ST_W       = $bits(periph_t);

   generate
      if (DATA_W < 8) begin : g_bad_width
         $error("DATA_W must be at least 8");
      end
      if (SETUP_TICKS < 1 || RESP_TICKS < 1) begin : g_bad_ticks
         $error("tick limits must be at least 1");
      end
      if (SYNC_STAGES < 0) begin : g_bad_sync
         $error("SYNC_STAGES must not be negative");
      end
   endgenerate

   phase_t            ph_q, ph_nxt;
   hostpins_t         pins_q, pins_nxt;
   result_t           res_q, res_nxt;
   logic [DATA_W-1:0] data_q, data_nxt, code_q, code_nxt, cur_q, cur_nxt;
   logic              act_q, act_nxt, done_q, done_nxt;
   logic [ST_W-1:0]   st_raw, st_sync;
   periph_t           st_q;
   logic              hit, expire, tmr_clr;
   logic [CNT_W-1:0]  limit;

   assign st_raw = {pin_nack, pin_busy, pin_perror, pin_select, pin_nfault};

   p1284_status_sync #(.W(ST_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(st_raw), .q(st_sync)
   );

   assign st_q = periph_t'(st_sync);

   p1284_event_match u_match (.ph(ph_q), .st(st_q), .hit(hit));

   always_comb begin
      unique case (ph_q)
         PH_N_SETUP, PH_N_STROBE: limit = CNT_W'(SETUP_TICKS);
         PH_N_REQ, PH_T_HSHK:     limit = CNT_W'(RESP_TICKS);
         PH_N_ACK, PH_T_REQ:      limit = CNT_W'(LONG_TICKS);
         default:                 limit = CNT_W'(1);
      endcase
   end

   assign tmr_clr = (ph_nxt != ph_q) || (ph_q == PH_IDLE);

   p1284_tick_timer #(.CNT_W(CNT_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .tick(tick),
      .limit(limit), .expire(expire)
   );

   always_comb begin
      ph_nxt   = ph_q;
      pins_nxt = pins_q;
      data_nxt = data_q;
      code_nxt = code_q;
      res_nxt  = res_q;
      act_nxt  = act_q;
      cur_nxt  = cur_q;
      done_nxt = 1'b0;
      unique case (ph_q)
         PH_IDLE: begin
            if (neg_start) begin
               if (pins_q.nselectin) begin
                  done_nxt = 1'b1;
                  res_nxt  = RES_IOERR;
               end else begin
                  ph_nxt   = PH_N_SETUP;
                  data_nxt = neg_code;
                  code_nxt = neg_code;
               end
            end else if (term_start) begin
               ph_nxt   = PH_T_REQ;
               pins_nxt = PINS_IDLE;
               act_nxt  = 1'b0;
               cur_nxt  = '0;
            end
         end
         PH_N_SETUP: begin
            if (expire) begin
               ph_nxt   = PH_N_REQ;
               pins_nxt = PINS_NREQ;
            end
         end
         PH_N_REQ: begin
            if (hit) begin
               ph_nxt           = PH_N_STROBE;
               pins_nxt.nstrobe = 1'b0;
            end else if (expire) begin
               ph_nxt   = PH_IDLE;
               done_nxt = 1'b1;
               res_nxt  = RES_TIMEOUT;
            end
         end
         PH_N_STROBE: begin
            if (expire) begin
               ph_nxt           = PH_N_ACK;
               pins_nxt.nstrobe = 1'b1;
               pins_nxt.nautofd = 1'b1;
            end
         end
         PH_N_ACK: begin
            if (hit) begin
               ph_nxt   = PH_IDLE;
               done_nxt = 1'b1;
               if (code_q[7:0] == NIBBLE_CODE || st_q.select) begin
                  res_nxt = RES_OK;
                  act_nxt = 1'b1;
                  cur_nxt = code_q;
               end else begin
                  res_nxt = RES_NOSUPP;
               end
            end else if (expire) begin
               ph_nxt   = PH_IDLE;
               done_nxt = 1'b1;
               res_nxt  = RES_IOERR;
            end
         end
         PH_T_REQ: begin
            if (hit) begin
               ph_nxt           = PH_T_HSHK;
               pins_nxt.nautofd = 1'b0;
            end else if (expire) begin
               ph_nxt   = PH_IDLE;
               done_nxt = 1'b1;
               res_nxt  = RES_IOERR;
            end
         end
         PH_T_HSHK: begin
            if (hit || expire) begin
               ph_nxt           = PH_IDLE;
               done_nxt         = 1'b1;
               pins_nxt.nautofd = 1'b1;
               res_nxt          = hit ? RES_OK : RES_IOERR;
            end
         end
         default: ph_nxt = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph_q   <= PH_IDLE;
         pins_q <= PINS_IDLE;
         data_q <= '0;
         code_q <= '0;
         res_q  <= RES_OK;
         act_q  <= 1'b0;
         cur_q  <= '0;
         done_q <= 1'b0;
      end else begin
         ph_q   <= ph_nxt;
         pins_q <= pins_nxt;
         data_q <= data_nxt;
         code_q <= code_nxt;
         res_q  <= res_nxt;
         act_q  <= act_nxt;
         cur_q  <= cur_nxt;
         done_q <= done_nxt;
      end
   end

   assign data_out      = data_q;
   assign out_nstrobe   = pins_q.nstrobe;
   assign out_nautofd   = pins_q.nautofd;
   assign out_ninit     = pins_q.ninit;
   assign out_nselectin = pins_q.nselectin;
   assign busy          = (ph_q != PH_IDLE);
   assign done          = done_q;
   assign result        = res_q;
   assign mode_active   = act_q;
   assign cur_mode      = cur_q;
endmodule

// File: rtl/p1284_negotiator_chk.sv
module p1284_negotiator_chk
   import p1284_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input phase_t            ph,
   input logic              neg_start,
   input logic              busy,
   input logic              done,
   input logic [1:0]        result,
   input logic              mode_active,
   input logic [DATA_W-1:0] data_out,
   input logic              out_nstrobe,
   input logic              out_nautofd,
   input logic              out_nselectin
);
   assert_idle_strobe_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> out_nstrobe);

   assert_refuse_selectin_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && neg_start && out_nselectin) |=> (done && result == 2'd2));

   assert_strobe_in_request_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !out_nstrobe |-> (out_nselectin && !out_nautofd));

   assert_nosupp_inactive_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (done && result == 2'd3) |-> !mode_active);

   assert_hshk_exit_autofd_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ph == PH_T_HSHK) |=> (ph == PH_T_HSHK || out_nautofd));

   assert_term_clears_mode_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (ph == PH_T_REQ || ph == PH_T_HSHK) |-> !mode_active);

   assert_data_hold_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> (!busy || $stable(data_out)));

   assert_done_when_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
endmodule

bind p1284_negotiator p1284_negotiator_chk #(.DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .ph(ph_q), .neg_start(neg_start), .busy(busy),
   .done(done), .result(result), .mode_active(mode_active), .data_out(data_out),
   .out_nstrobe(out_nstrobe), .out_nautofd(out_nautofd), .out_nselectin(out_nselectin)
);

// File: tb/sim_p1284_negotiator.sv
module sim_p1284_negotiator;
   localparam int CLK_PERIOD = 10;
   localparam int SETUP      = 1;
   localparam int RESP       = 6;

   logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
   logic neg_start = 1'b0, term_start = 1'b0;
   logic [7:0] neg_code = 8'h00;
   logic pin_nack = 1'b1, pin_busy = 1'b0, pin_perror = 1'b0, pin_select = 1'b0, pin_nfault = 1'b1;
   logic [7:0] data_out, cur_mode;
   logic out_nstrobe, out_nautofd, out_ninit, out_nselectin, busy, done, mode_active;
   logic [1:0] result;

   p1284_negotiator #(.SETUP_TICKS(SETUP), .RESP_TICKS(RESP), .SYNC_STAGES(2)) u0 (
      .clk(clk), .rst_n(rst_n), .tick(tick), .neg_start(neg_start), .neg_code(neg_code),
      .term_start(term_start), .pin_nack(pin_nack), .pin_busy(pin_busy),
      .pin_perror(pin_perror), .pin_select(pin_select), .pin_nfault(pin_nfault),
      .data_out(data_out), .out_nstrobe(out_nstrobe), .out_nautofd(out_nautofd),
      .out_ninit(out_ninit), .out_nselectin(out_nselectin), .busy(busy), .done(done),
      .result(result), .mode_active(mode_active), .cur_mode(cur_mode)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int n_chk = 0, n_fail = 0, cyc = 0;
   bit finished = 1'b0;

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
      end
   endtask

   // tick strobe
   int tick_div = 3;
   int tick_ctr = 0;
   always @(negedge clk) begin
      tick_ctr++;
      tick = ((tick_ctr % tick_div) == 0);
   end

   // scripted peripheral
   bit p_on = 1'b1, p_sel = 1'b1;
   bit mute_req = 1'b0, mute_ack = 1'b0, mute_treq = 1'b0, mute_ths = 1'b0;
   always @(negedge clk) begin
      if (p_on && rst_n) begin
         if (out_nselectin && !out_nautofd) begin
            if (!mute_req) begin
               pin_nack = 1'b0; pin_perror = 1'b1; pin_select = 1'b1; pin_nfault = 1'b1;
            end
         end else if (out_nselectin && out_nautofd) begin
            if (!mute_ack) begin
               pin_nack = 1'b1; pin_select = p_sel;
            end
         end else if (!out_nselectin && out_nautofd) begin
            if (!mute_treq) begin
               pin_busy = 1'b1; pin_nfault = 1'b1; pin_nack = 1'b0;
            end
         end else begin
            if (!mute_ths) pin_nack = 1'b1;
         end
      end
   end

   // behavioural reference model
   int m_ph, m_cnt, m_res;
   bit m_stb, m_afd, m_ini, m_sel, m_act, m_done;
   logic [7:0] m_data, m_code, m_cur;
   logic [4:0] m_s0, m_s1;

   always @(posedge clk) begin
      logic [4:0] v;
      bit hit, expd;
      int lim, nph;
      if (!rst_n) begin
         m_ph = 0; m_cnt = 0; m_res = 0; m_stb = 1; m_afd = 1; m_ini = 1; m_sel = 0;
         m_act = 0; m_done = 0; m_data = 0; m_code = 0; m_cur = 0; m_s0 = 0; m_s1 = 0;
      end else begin
         v = m_s1;
         m_s1 = m_s0;
         m_s0 = {pin_nack, pin_busy, pin_perror, pin_select, pin_nfault};
         m_done = 0;
         nph = m_ph;
         case (m_ph)
            1, 3:    lim = SETUP;
            2, 6:    lim = RESP;
            4, 5:    lim = SETUP + RESP;
            default: lim = 1;
         endcase
         expd = tick && (m_cnt == lim - 1);
         case (m_ph)
            2:       hit = v[2] && v[1] && v[0] && !v[4];
            4, 6:    hit = v[4];
            5:       hit = v[3] && v[0] && !v[4];
            default: hit = 0;
         endcase
         case (m_ph)
            0: if (neg_start) begin
                  if (m_sel) begin m_done = 1; m_res = 2; end
                  else begin nph = 1; m_data = neg_code; m_code = neg_code; end
               end else if (term_start) begin
                  nph = 5; m_sel = 0; m_afd = 1; m_stb = 1; m_ini = 1; m_act = 0; m_cur = 0;
               end
            1: if (expd) begin nph = 2; m_sel = 1; m_afd = 0; end
            2: if (hit) begin nph = 3; m_stb = 0; end
               else if (expd) begin nph = 0; m_done = 1; m_res = 1; end
            3: if (expd) begin nph = 4; m_stb = 1; m_afd = 1; end
            4: if (hit) begin
                  nph = 0; m_done = 1;
                  if (m_code == 8'h00 || v[1]) begin m_res = 0; m_act = 1; m_cur = m_code; end
                  else m_res = 3;
               end else if (expd) begin nph = 0; m_done = 1; m_res = 2; end
            5: if (hit) begin nph = 6; m_afd = 0; end
               else if (expd) begin nph = 0; m_done = 1; m_res = 2; end
            6: if (hit || expd) begin
                  nph = 0; m_done = 1; m_afd = 1; m_res = hit ? 0 : 2;
               end
            default: nph = 0;
         endcase
         if (nph != m_ph || m_ph == 0) m_cnt = 0;
         else if (tick) m_cnt++;
         m_ph = nph;
      end
   end

   // per-cycle comparison
   always @(negedge clk) begin
      string tag;
      if (rst_n && !finished) begin
         tag = (m_ph == 0) ? "R1" : (m_ph < 5) ? "R3 R12" : "R7 R12";
         chk({tag, " pins"}, {out_nselectin, out_ninit, out_nautofd, out_nstrobe},
             {m_sel, m_ini, m_afd, m_stb});
         chk({tag, " data/busy"}, {busy, data_out}, {(m_ph != 0), m_data});
         chk("R11 done/result", {done, result}, {m_done, 2'(m_res)});
         chk("R6 mode", {mode_active, cur_mode}, {m_act, m_cur});
      end
   end

   // operations
   int last_res, last_wait;
   task automatic wait_done();
      last_res = -1;
      for (int i = 0; i < 600; i++) begin
         if (done) begin last_res = result; last_wait = i; return; end
         @(negedge clk);
      end
   endtask

   task automatic do_neg(input logic [7:0] code);
      @(negedge clk); neg_start = 1'b1; neg_code = code;
      @(negedge clk); neg_start = 1'b0;
      wait_done();
   endtask

   task automatic do_term();
      @(negedge clk); term_start = 1'b1;
      @(negedge clk); term_start = 1'b0;
      wait_done();
   endtask

   task automatic lines_default();
      pin_nack = 1'b1; pin_busy = 1'b0; pin_perror = 1'b0; pin_select = 1'b0; pin_nfault = 1'b1;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000 && !finished) begin
         finished = 1'b1;
         n_fail++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 reset pins", {out_nselectin, out_ninit, out_nautofd, out_nstrobe}, 4'b0111);
      chk("R1 reset state", {busy, done, result, mode_active, data_out}, '0);

      // nibble accepted without Select
      p_sel = 1'b0;
      do_neg(8'h00);
      chk("R6 nibble result", last_res, 0);
      chk("R6 nibble active", {mode_active, cur_mode}, {1'b1, 8'h00});
      chk("R3 selectin held high", out_nselectin, 1'b1);

      // refused because nSelectIn is high
      do_neg(8'h30);
      chk("R2 refusal result", last_res, 2);
      chk("R2 refusal immediate", last_wait, 0);
      chk("R2 data unchanged", data_out, 8'h00);

      do_term();
      chk("R7 term result", last_res, 0);
      chk("R9 term mode cleared", mode_active, 1'b0);
      chk("R7 term pins", {out_nselectin, out_ninit, out_nautofd, out_nstrobe}, 4'b0111);

      // non-nibble code accepted with Select high
      p_sel = 1'b1;
      do_neg(8'h30);
      chk("R6 ecp result", last_res, 0);
      chk("R6 ecp mode", {mode_active, cur_mode}, {1'b1, 8'h30});

      // second termination wait times out
      mute_ths = 1'b1;
      do_term();
      chk("R8 hshk timeout result", last_res, 2);
      chk("R8 autofd restored", out_nautofd, 1'b1);
      chk("R9 mode cleared on failure", {mode_active, cur_mode}, 9'h000);
      mute_ths = 1'b0;

      // non-nibble code refused without Select
      lines_default();
      p_sel = 1'b0;
      do_neg(8'h30);
      chk("R6 nosupp result", last_res, 3);
      chk("R6 nosupp inactive", mode_active, 1'b0);
      do_term();
      chk("R7 term after nosupp", last_res, 0);

      // no response to the request pattern
      lines_default();
      mute_req = 1'b1;
      do_neg(8'h10);
      chk("R4 timeout result", last_res, 1);
      chk("R4 waited for ticks", (last_wait >= RESP * tick_div) ? 1 : 0, 1);
      mute_req = 1'b0;
      do_term();

      // nAck never returns high
      p_sel = 1'b1;
      mute_ack = 1'b1;
      do_neg(8'h00);
      chk("R5 ack timeout result", last_res, 2);
      chk("R5 inactive", mode_active, 1'b0);
      mute_ack = 1'b0;
      do_term();

      // first termination wait times out
      do_neg(8'h00);
      mute_treq = 1'b1;
      pin_busy = 1'b0;
      do_term();
      chk("R8 treq timeout result", last_res, 2);
      chk("R9 mode cleared", mode_active, 1'b0);
      mute_treq = 1'b0;

      // requests while busy are ignored
      @(negedge clk); term_start = 1'b1;
      @(negedge clk); term_start = 1'b0; neg_start = 1'b1; neg_code = 8'h55;
      @(negedge clk); neg_start = 1'b0;
      chk("R10 start ignored while busy", (data_out != 8'h55) ? 1 : 0, 1);
      wait_done();
      chk("R10 term completed", last_res, 0);
      chk("R10 data untouched", (data_out != 8'h55) ? 1 : 0, 1);

      // start wins over terminate
      @(negedge clk); neg_start = 1'b1; term_start = 1'b1; neg_code = 8'h12;
      @(negedge clk); neg_start = 1'b0; term_start = 1'b0;
      chk("R10 start priority", {busy, data_out, out_nselectin}, {1'b1, 8'h12, 1'b0});
      wait_done();
      chk("R10 priority result", {last_res[1:0], mode_active, cur_mode}, {2'd0, 1'b1, 8'h12});

      // fast tick
      tick_div = 1;
      do_term();
      chk("R12 fast term", last_res, 0);
      do_neg(8'h00);
      chk("R12 fast neg", last_res, 0);
      do_term();

      repeat (5) @(negedge clk);
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end
endmodule